// File: doc/BRIEF.md
# Nesting Interrupt CPU Interface

This block sits between an interrupt distributor and one processor. The distributor supplies the ID and priority of its best pending interrupt. The block decides whether that interrupt may interrupt the processor, and drives a single IRQ line when it may. Software uses a small register window to accept an interrupt and to retire it. Accepting is a read that returns the interrupt ID. Retiring is an end-of-interrupt write that carries the ID.

The block keeps track of the running interrupt and its priority. An interrupt can preempt the one that is running. When that happens, the block stores a "previously active" link for the new interrupt. Handlers may retire interrupts in any order. Retiring the running interrupt restores its predecessor. Retiring an interrupt that is buried in the chain removes it from the chain and leaves the running interrupt unchanged. That removal is a walk of one link per clock, and the bus is held through `bus_ready` until the walk ends.

The block returns two kinds of request to the distributor. A clear-pending request follows each successful accept. A set-pending request follows the end-of-interrupt of a level source whose line is still high.

Top module: `irq_cpu_if`

## Requirements
- R1: After reset: control reads 0, the priority mask (offset 0x04) reads 0xF0, running priority (offset 0x14) reads 0x100, highest pending (offset 0x18) reads 1023, and `irq` is low.
- R2: `irq` is high only when `dist_en` is high, control bit 0 is set, `best_id` is a real source below NUM_IRQ, `best_prio` is less than or equal to the mask, and `best_prio` is strictly less than the running priority.
- R3: A read of offset 0x0C returns 1023 and has no side effect when nothing passes the mask, or when the pending priority is not strictly below the running priority. Otherwise it returns the ID, pulses `clr_pend_vld` with that ID, and makes that ID the running interrupt with its own priority.
- R4: A write of offset 0x10 while the running ID is 1023 has no effect at all.
- R5: At an end-of-interrupt (offset 0x10, ID in bits [9:0]) for a source that is level-triggered (`src_edge` bit 0), enabled, and whose level is still high, `set_pend_vld` pulses with that ID. An edge-triggered source gives no such pulse.
- R6: End-of-interrupt of the running ID makes its recorded predecessor the running interrupt. The running priority becomes that predecessor's priority, or 0x100 when the predecessor is 1023.
- R7: End-of-interrupt of an ID that is not the running one removes that ID from the preemption chain and leaves the running ID unchanged. `bus_ready` stays low for one cycle plus one cycle per link visited.
- R8: Offset 0x08 reads 0, and writes to it change nothing. Offset 0x18 reads the masked best pending ID, or 1023.
- R9: A write of offset 0x04 sets the mask from bits [7:0], and the mask reads back from offset 0x04. A best priority above the mask keeps `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dist_en | input | 1 | Distributor global enable |
| best_id | input | 10 | Best pending interrupt ID from the distributor |
| best_prio | input | 8 | Priority of `best_id` (lower value means more urgent) |
| src_prio | input | NUM_IRQ*8 | Priority of every source, one byte per source |
| src_edge | input | NUM_IRQ | 1 = edge-triggered source |
| src_en | input | NUM_IRQ | Per-source enable |
| src_level | input | NUM_IRQ | Current input line level per source |
| bus_req | input | 1 | Register access request, held until `bus_ready` |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset in the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_ready` is high |
| bus_ready | output | 1 | Access completes in this cycle |
| irq | output | 1 | Interrupt request to the processor |
| clr_pend_vld | output | 1 | Request to clear a pending bit |
| clr_pend_id | output | 10 | ID to clear |
| set_pend_vld | output | 1 | Request to set a pending bit again |
| set_pend_id | output | 10 | ID to set |

## Verification
The hardest case to reach is an end-of-interrupt for an interrupt buried in the middle of a chain at least three deep. That case needs three successive preemptions, each one at a strictly better priority than the last. The bench reaches it by driving the best ID and priority directly, one step at a time, and accepting each interrupt before it presents the next. It then retires the middle and the bottom entries out of order, and counts the stall cycles. Finally it unwinds the chain in order and checks that each predecessor's priority returns.

// File: rtl/icpu_pkg.sv
package icpu_pkg;
  localparam int ID_W       = 10;
  localparam int PRIO_W     = 8;
  localparam int RPRIO_W    = PRIO_W + 1;
  localparam logic [ID_W-1:0]    IDLE_ID   = 10'd1023;
  localparam logic [RPRIO_W-1:0] IDLE_PRIO = 9'h100;
  localparam logic [PRIO_W-1:0]  MASK_RST  = 8'hF0;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_MASK = 8'h04;
  localparam logic [7:0] OFS_BPT  = 8'h08;
  localparam logic [7:0] OFS_ACK  = 8'h0C;
  localparam logic [7:0] OFS_EOI  = 8'h10;
  localparam logic [7:0] OFS_RUNP = 8'h14;
  localparam logic [7:0] OFS_HPND = 8'h18;

  typedef enum logic [1:0] {WK_IDLE, WK_STEP, WK_FIN} walk_st_e;
endpackage

// File: rtl/icpu_pend_eval.sv
module icpu_pend_eval
  import icpu_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic               dist_en,
  input  logic               cpu_en,
  input  logic [ID_W-1:0]    best_id,
  input  logic [PRIO_W-1:0]  best_prio,
  input  logic [PRIO_W-1:0]  mask,
  input  logic [RPRIO_W-1:0] run_prio,
  output logic [ID_W-1:0]    cur_pend_id,
  output logic               take_ok
);
  logic src_real;
  logic passes_mask;

  always_comb begin
    src_real    = (32'(best_id) < NUM_IRQ);
    passes_mask = dist_en && cpu_en && src_real && (best_prio <= mask);
    cur_pend_id = passes_mask ? best_id : IDLE_ID;
    take_ok     = passes_mask && ({1'b0, best_prio} < run_prio);
  end
endmodule

// File: rtl/icpu_chain.sv
module icpu_chain
  import icpu_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_IRQ*PRIO_W-1:0] src_prio,
  input  logic                      push_vld,
  input  logic [ID_W-1:0]           push_id,
  input  logic                      pop_vld,
  input  logic                      walk_start,
  input  logic [ID_W-1:0]           walk_id,
  output logic [ID_W-1:0]           run_id,
  output logic [RPRIO_W-1:0]        run_prio,
  output walk_st_e                  walk_st
);
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic [ID_W-1:0]    link_q [NUM_IRQ];
  logic [ID_W-1:0]    link_d [NUM_IRQ];
  logic [ID_W-1:0]    run_id_q, run_id_d;
  logic [RPRIO_W-1:0] run_prio_q, run_prio_d;
  logic [IDX_W-1:0]   ptr_q, ptr_d;
  logic [ID_W-1:0]    tgt_q, tgt_d;
  walk_st_e           st_q, st_d;
  logic [ID_W-1:0]    nxt;

  function automatic logic [IDX_W-1:0] to_idx(input logic [ID_W-1:0] id);
    return id[IDX_W-1:0];
  endfunction

  function automatic logic [RPRIO_W-1:0] prio_of(input logic [ID_W-1:0] id,
                                                 input logic [NUM_IRQ*PRIO_W-1:0] tbl);
    if (id == IDLE_ID) return IDLE_PRIO;
    return {1'b0, tbl[int'(to_idx(id))*PRIO_W +: PRIO_W]};
  endfunction

  always_comb begin
    for (int i = 0; i < NUM_IRQ; i++) link_d[i] = link_q[i];
    run_id_d   = run_id_q;
    run_prio_d = run_prio_q;
    ptr_d      = ptr_q;
    tgt_d      = tgt_q;
    st_d       = st_q;
    nxt        = link_q[ptr_q];
    case (st_q)
      WK_IDLE: begin
        if (push_vld) begin
          link_d[to_idx(push_id)] = run_id_q;
          run_id_d   = push_id;
          run_prio_d = prio_of(push_id, src_prio);
        end else if (pop_vld) begin
          run_id_d   = link_q[to_idx(run_id_q)];
          run_prio_d = prio_of(link_q[to_idx(run_id_q)], src_prio);
        end else if (walk_start) begin
          ptr_d = to_idx(run_id_q);
          tgt_d = walk_id;
          st_d  = WK_STEP;
        end
      end
      WK_STEP: begin
        if (nxt == IDLE_ID) begin
          st_d = WK_FIN;
        end else if (nxt == tgt_q) begin
          link_d[ptr_q] = link_q[to_idx(tgt_q)];
          st_d = WK_FIN;
        end else begin
          ptr_d = to_idx(nxt);
        end
      end
      default: st_d = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_IRQ; i++) link_q[i] <= IDLE_ID;
      run_id_q   <= IDLE_ID;
      run_prio_q <= IDLE_PRIO;
      ptr_q      <= '0;
      tgt_q      <= IDLE_ID;
      st_q       <= WK_IDLE;
    end else begin
      for (int i = 0; i < NUM_IRQ; i++) link_q[i] <= link_d[i];
      run_id_q   <= run_id_d;
      run_prio_q <= run_prio_d;
      ptr_q      <= ptr_d;
      tgt_q      <= tgt_d;
      st_q       <= st_d;
    end
  end

  assign run_id   = run_id_q;
  assign run_prio = run_prio_q;
  assign walk_st  = st_q;

  AST_IDLE_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (run_id_q == IDLE_ID) |-> (run_prio_q == IDLE_PRIO)); // R6
  AST_PUSH_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (push_vld && st_q == WK_IDLE) |=> (run_id_q == $past(push_id))); // R3
  AST_WALK_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != WK_IDLE) |=> $stable(run_id_q)); // R7
endmodule

// File: rtl/irq_cpu_if.sv
module irq_cpu_if
  import icpu_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      dist_en,
  input  logic [9:0]                best_id,
  input  logic [7:0]                best_prio,
  input  logic [NUM_IRQ*8-1:0]      src_prio,
  input  logic [NUM_IRQ-1:0]        src_edge,
  input  logic [NUM_IRQ-1:0]        src_en,
  input  logic [NUM_IRQ-1:0]        src_level,
  input  logic                      bus_req,
  input  logic                      bus_wr,
  input  logic [7:0]                bus_addr,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  output logic                      bus_ready,
  output logic                      irq,
  output logic                      clr_pend_vld,
  output logic [9:0]                clr_pend_id,
  output logic                      set_pend_vld,
  output logic [9:0]                set_pend_id
);
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic               cpu_en_q, cpu_en_d;
  logic [PRIO_W-1:0]  mask_q, mask_d;
  logic [ID_W-1:0]    run_id;
  logic [RPRIO_W-1:0] run_prio;
  logic [ID_W-1:0]    cur_pend_id;
  logic               take_ok;
  walk_st_e           walk_st;

  logic               acc, is_ack, is_eoi, eoi_live, eoi_src_ok;
  logic [ID_W-1:0]    eoi_id;
  logic [IDX_W-1:0]   eoi_idx;
  logic               push_vld, pop_vld, walk_start;

  icpu_pend_eval #(.NUM_IRQ(NUM_IRQ)) u_eval (
    .dist_en     (dist_en),
    .cpu_en      (cpu_en_q),
    .best_id     (best_id),
    .best_prio   (best_prio),
    .mask        (mask_q),
    .run_prio    (run_prio),
    .cur_pend_id (cur_pend_id),
    .take_ok     (take_ok)
  );

  icpu_chain #(.NUM_IRQ(NUM_IRQ)) u_chain (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_prio   (src_prio),
    .push_vld   (push_vld),
    .push_id    (best_id),
    .pop_vld    (pop_vld),
    .walk_start (walk_start),
    .walk_id    (eoi_id),
    .run_id     (run_id),
    .run_prio   (run_prio),
    .walk_st    (walk_st)
  );

  always_comb begin
    acc        = bus_req && (walk_st == WK_IDLE);
    is_ack     = acc && !bus_wr && (bus_addr == OFS_ACK);
    is_eoi     = acc && bus_wr && (bus_addr == OFS_EOI);
    eoi_id     = bus_wdata[ID_W-1:0];
    eoi_idx    = eoi_id[IDX_W-1:0];
    eoi_src_ok = (32'(eoi_id) < NUM_IRQ);
    eoi_live   = is_eoi && (run_id != IDLE_ID);
    push_vld   = is_ack && take_ok;
    pop_vld    = eoi_live && (eoi_id == run_id);
    walk_start = eoi_live && eoi_src_ok && (eoi_id != run_id);

    bus_ready  = (acc && !walk_start) || (walk_st == WK_FIN);

    irq          = take_ok;
    clr_pend_vld = push_vld;
    clr_pend_id  = push_vld ? best_id : IDLE_ID;
    set_pend_vld = eoi_live && eoi_src_ok && !src_edge[eoi_idx]
                   && src_en[eoi_idx] && src_level[eoi_idx];
    set_pend_id  = set_pend_vld ? eoi_id : IDLE_ID;

    cpu_en_d = cpu_en_q;
    mask_d   = mask_q;
    if (acc && bus_wr && bus_addr == OFS_CTRL) cpu_en_d = bus_wdata[0];
    if (acc && bus_wr && bus_addr == OFS_MASK) mask_d   = bus_wdata[PRIO_W-1:0];

    bus_rdata = '0;
    case (bus_addr)
      OFS_CTRL: bus_rdata = {31'd0, cpu_en_q};
      OFS_MASK: bus_rdata = {{(32-PRIO_W){1'b0}}, mask_q};
      OFS_BPT:  bus_rdata = '0;
      OFS_ACK:  bus_rdata = {{(32-ID_W){1'b0}}, (take_ok ? best_id : IDLE_ID)};
      OFS_RUNP: bus_rdata = {{(32-RPRIO_W){1'b0}}, run_prio};
      OFS_HPND: bus_rdata = {{(32-ID_W){1'b0}}, cur_pend_id};
      default:  bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_en_q <= 1'b0;
      mask_q   <= MASK_RST;
    end else begin
      cpu_en_q <= cpu_en_d;
      mask_q   <= mask_d;
    end
  end

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (dist_en && cpu_en_q && best_prio <= mask_q)); // R2
  AST_ACK_BELOW_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pend_vld |-> ({1'b0, best_prio} < run_prio)); // R3
  AST_EOI_IDLE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (is_eoi && run_id == IDLE_ID) |=> (run_id == IDLE_ID && !set_pend_vld)); // R4
  AST_STALL_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_st == WK_STEP) |-> !bus_ready); // R7
  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clr_pend_vld, set_pend_vld})); // R5
endmodule

// File: tb/sim_irq_cpu_if.sv
module sim_irq_cpu_if;
  localparam int PERIOD  = 10;
  localparam int NUM_IRQ = 32;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               dist_en;
  logic [9:0]         best_id;
  logic [7:0]         best_prio;
  logic [NUM_IRQ*8-1:0] src_prio;
  logic [NUM_IRQ-1:0] src_edge, src_en, src_level;
  logic               bus_req, bus_wr;
  logic [7:0]         bus_addr;
  logic [31:0]        bus_wdata;
  logic [31:0]        bus_rdata;
  logic               bus_ready, irq;
  logic               clr_pend_vld, set_pend_vld;
  logic [9:0]         clr_pend_id, set_pend_id;

  int n_tests = 0;
  int n_fail  = 0;

  irq_cpu_if #(.NUM_IRQ(NUM_IRQ)) u0 (.*);

  always #(PERIOD/2) clk = ~clk;

  // transaction results
  logic [31:0] rd;
  int          stalls;
  logic        got_clr, got_set;
  logic [9:0]  clr_id_seen, set_id_seen;

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [7:0] addr, input logic [31:0] wd);
    logic done;
    @(negedge clk);
    bus_req = 1'b1; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
    stalls = 0; got_clr = 1'b0; got_set = 1'b0; done = 1'b0;
    clr_id_seen = 10'h3FF; set_id_seen = 10'h3FF;
    while (!done) begin
      #(PERIOD/4);
      if (clr_pend_vld) begin got_clr = 1'b1; clr_id_seen = clr_pend_id; end
      if (set_pend_vld) begin got_set = 1'b1; set_id_seen = set_pend_id; end
      if (bus_ready) begin
        rd = bus_rdata; done = 1'b1;
      end else begin
        stalls++;
        @(negedge clk);
      end
    end
    @(posedge clk);
    #1 bus_req = 1'b0;
  endtask

  task automatic set_best(input logic [9:0] id, input logic [7:0] p);
    @(negedge clk);
    best_id = id; best_prio = p;
  endtask

  task automatic set_prio(input int id, input logic [7:0] p);
    src_prio[id*8 +: 8] = p;
  endtask

  task automatic irq_now(output logic v);
    @(negedge clk); #(PERIOD/4); v = irq;
  endtask

  task automatic t_reset;
    logic v;
    xfer(1'b0, 8'h00, 0); check(rd == 0, "R1 ctrl", rd, 0);
    xfer(1'b0, 8'h04, 0); check(rd == 32'hF0, "R1 mask", rd, 32'hF0);
    xfer(1'b0, 8'h14, 0); check(rd == 32'h100, "R1 runprio", rd, 32'h100);
    xfer(1'b0, 8'h18, 0); check(rd == 1023, "R1 hpend", rd, 1023);
    irq_now(v); check(v == 1'b0, "R1 irq", v, 0);
  endtask

  task automatic t_eoi_idle;
    xfer(1'b1, 8'h10, 32'd4);
    check(!got_set, "R4 no set-pend", got_set, 0);
    xfer(1'b0, 8'h14, 0); check(rd == 32'h100, "R4 runprio", rd, 32'h100);
  endtask

  task automatic t_gate;
    logic v;
    set_best(10'd3, 8'h80);
    irq_now(v); check(v == 1'b0, "R2 cpu off", v, 0);
    xfer(1'b1, 8'h00, 32'h1);
    irq_now(v); check(v == 1'b1, "R2 enabled", v, 1);
    dist_en = 1'b0;
    irq_now(v); check(v == 1'b0, "R2 dist off", v, 0);
    dist_en = 1'b1;
    set_best(10'd3, 8'hF1);
    irq_now(v); check(v == 1'b0, "R2 above mask", v, 0);
    xfer(1'b0, 8'h18, 0); check(rd == 1023, "R8 hpend masked", rd, 1023);
    set_best(10'd3, 8'hF0);
    irq_now(v); check(v == 1'b1, "R2 at mask", v, 1);
    xfer(1'b0, 8'h18, 0); check(rd == 3, "R8 hpend", rd, 3);
  endtask

  task automatic t_mask_bpt;
    logic v;
    xfer(1'b1, 8'h04, 32'h50);
    xfer(1'b0, 8'h04, 0); check(rd == 32'h50, "R9 mask rb", rd, 32'h50);
    set_best(10'd3, 8'h60);
    irq_now(v); check(v == 1'b0, "R9 masked", v, 0);
    xfer(1'b1, 8'h08, 32'hFF);
    xfer(1'b0, 8'h08, 0); check(rd == 0, "R8 bpt", rd, 0);
    xfer(1'b0, 8'h04, 0); check(rd == 32'h50, "R8 bpt no effect", rd, 32'h50);
    xfer(1'b1, 8'h04, 32'hF0);
  endtask

  task automatic t_nest;
    logic v;
    set_best(10'd3, 8'h80);
    xfer(1'b0, 8'h0C, 0); check(rd == 3, "R3 ack3", rd, 3);
    check(got_clr && clr_id_seen == 3, "R3 clr3", clr_id_seen, 3);
    xfer(1'b0, 8'h14, 0); check(rd == 32'h80, "R3 runprio", rd, 32'h80);
    irq_now(v); check(v == 1'b0, "R3 irq drops", v, 0);
    xfer(1'b0, 8'h0C, 0); check(rd == 1023, "R3 ack not below", rd, 1023);
    check(!got_clr, "R3 no clr", got_clr, 0);
    set_best(10'd5, 8'h40);
    xfer(1'b0, 8'h0C, 0); check(rd == 5, "R3 ack5", rd, 5);
    set_best(10'd7, 8'h20);
    xfer(1'b0, 8'h0C, 0); check(rd == 7, "R3 ack7", rd, 7);
    set_best(10'd1023, 8'hFF);
    // chain 7 -> 5 -> 3; retire 5 out of order: one link visited
    xfer(1'b1, 8'h10, 32'd5);
    check(stalls == 2, "R7 stall mid", stalls, 2);
    xfer(1'b0, 8'h14, 0); check(rd == 32'h20, "R7 run kept", rd, 32'h20);
    xfer(1'b1, 8'h10, 32'd7);
    check(stalls == 0, "R6 no stall", stalls, 0);
    xfer(1'b0, 8'h14, 0); check(rd == 32'h80, "R6 pred prio", rd, 32'h80);
    xfer(1'b1, 8'h10, 32'd3);
    xfer(1'b0, 8'h14, 0); check(rd == 32'h100, "R6 idle prio", rd, 32'h100);
  endtask

  task automatic t_deep;
    set_best(10'd3, 8'h80); xfer(1'b0, 8'h0C, 0);
    set_best(10'd5, 8'h40); xfer(1'b0, 8'h0C, 0);
    set_best(10'd7, 8'h20); xfer(1'b0, 8'h0C, 0);
    set_best(10'd1023, 8'hFF);
    xfer(1'b1, 8'h10, 32'd3);
    check(stalls == 3, "R7 stall deep", stalls, 3);
    xfer(1'b1, 8'h10, 32'd7);
    xfer(1'b0, 8'h14, 0); check(rd == 32'h40, "R7 pred after splice", rd, 32'h40);
    xfer(1'b1, 8'h10, 32'd5);
    xfer(1'b0, 8'h14, 0); check(rd == 32'h100, "R7 unwound", rd, 32'h100);
  endtask

  task automatic t_level;
    set_best(10'd4, 8'h60);
    xfer(1'b0, 8'h0C, 0); check(rd == 4, "R5 ack4", rd, 4);
    set_best(10'd1023, 8'hFF);
    xfer(1'b1, 8'h10, 32'd4);
    check(got_set && set_id_seen == 4, "R5 re-pend", set_id_seen, 4);
    set_best(10'd3, 8'h80);
    xfer(1'b0, 8'h0C, 0);
    set_best(10'd1023, 8'hFF);
    xfer(1'b1, 8'h10, 32'd3);
    check(!got_set, "R5 edge no re-pend", got_set, 0);
  endtask

  initial begin
    rst_n = 1'b0; dist_en = 1'b1; best_id = 10'd1023; best_prio = 8'hFF;
    src_prio = '1; src_edge = '0; src_en = '0; src_level = '0;
    bus_req = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    set_prio(3, 8'h80); set_prio(5, 8'h40); set_prio(7, 8'h20); set_prio(4, 8'h60);
    src_edge[3] = 1'b1; src_en[3] = 1'b1;
    src_en[4] = 1'b1; src_level[4] = 1'b1;
    src_en[5] = 1'b1; src_en[7] = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_eoi_idle();
    t_gate();
    t_mask_bpt();
    t_nest();
    t_deep();
    t_level();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(PERIOD*50000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule